// File: doc/BRIEF.md
# Zero-Substituting Transmit Line Encoder

This block sits in one transmit channel of a coaxial line interface, between the framer-side data pins and the pulse shaper. It takes data sampled on the transmit clock and produces two rail signals, `line_pos` and `line_neg`. A pulse on either rail stands for a positive or a negative line mark. In normal operation a single NRZ stream is turned into alternate-mark-inversion pulses. Long runs of zeros are replaced with patterns that carry a deliberate bipolar violation. With `mode_e3` low the block uses three-zero substitution (B3ZS, DS3/STS-1 rates). With `mode_e3` high it uses four-zero substitution (HDB3, E3 rate).

Three selections are made ahead of the encoder. An alarm-force input replaces the traffic with an all-ones stream that is then encoded, so the line carries alternating marks. A remote-loopback input replaces the traffic with retimed receive data, which is also encoded. An encoder-bypass input lets a framer that already produces dual-rail pulses drive both rails directly. All paths have the same fixed delay of four clock cycles, which leaves room for the zero-run lookahead.

Top module: `line_zs_encoder`

## Requirements
- R1: While `rst` is high, and for the first four rising edges after it falls, both `line_pos` and `line_neg` are 0.
- R2: A bit present on the inputs at rising edge k shows on the outputs after rising edge k+4. This delay is the same in every mode and on every source path.
- R3: With `enc_bypass`=1, `ais_force`=0 and `rlb_en`=0, `tx_d0` and `tx_d1` appear unchanged on `line_pos` and `line_neg`.
- R4: With `enc_bypass`=0 and no alarm or loopback, `tx_d0` is the NRZ data (1 = mark). `tx_d1` has no effect on the outputs.
- R5: In encoded operation, each NRZ 1 gives a pulse on exactly one rail. Successive marks alternate in polarity, and the first pulse after reset is on `line_pos`. Both rails are high together only on the bypass path.
- R6: With `mode_e3`=0, every run of three zeros, taken in order from the left, is sent as 00V if an odd number of pulses has gone out since the last violation, or as B0V if that number is even. At reset the count is taken as even.
- R7: With `mode_e3`=1, every run of four zeros is sent as 000V (odd count) or B00V (even count), by the same counting rule as R6.
- R8: A B pulse takes the polarity opposite to the previous pulse and counts as a mark. A V pulse repeats the polarity of the previous pulse and resets the count to even.
- R9: `ais_force`=1 replaces the data with an all-ones NRZ stream and encodes it, whatever the state of `enc_bypass` and `rlb_en`.
- R10: `rlb_en`=1 (with `ais_force`=0) replaces the data with `rlb_data` as NRZ and encodes it, even when `enc_bypass`=1.
- R11: While the encoded source and mode are held, the line never shows more than 2 zero slots in a row with B3ZS, or more than 3 with HDB3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock; all inputs sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_e3 | input | 1 | 1 = HDB3 (E3), 0 = B3ZS (DS3/STS-1) |
| enc_bypass | input | 1 | 1 = inputs are already dual-rail pulses |
| ais_force | input | 1 | Send alarm (all ones, encoded) |
| rlb_en | input | 1 | Send retimed receive data instead of local data |
| tx_d0 | input | 1 | NRZ data, or positive rail in bypass |
| tx_d1 | input | 1 | Negative rail in bypass, ignored otherwise |
| rlb_data | input | 1 | Retimed receive NRZ data for remote loopback |
| line_pos | output | 1 | Positive-mark pulse to the shaper |
| line_neg | output | 1 | Negative-mark pulse to the shaper |

## Verification
The encoder is driven with NRZ streams that mix single marks, runs of exactly the substitution length, runs two or three times that length, and runs one zero short of it. These patterns separate a correct odd/even choice between the two substitution forms, correct left-to-right grouping of long runs, and the absence of false substitution. The same stream goes through B3ZS and HDB3 so that the two run lengths are told apart, and once with `tx_d1` carrying its complement to show that the pin has no effect. Alarm and loopback runs, with and without bypass, show the priority order. A raw dual-rail run that includes both rails high shows that the bypass path does no coding.

// File: rtl/zs_enc_pkg.sv
package zs_enc_pkg;
  localparam int unsigned WIN     = 4;   // slots in the lookahead window = latency
  localparam int unsigned RUN_E3  = 4;   // zero run replaced in HDB3
  localparam int unsigned RUN_DS3 = 3;   // zero run replaced in B3ZS

  typedef enum logic [1:0] {
    TG_DATA  = 2'd0,   // plain NRZ bit in p
    TG_SUBZ  = 2'd1,   // zero that belongs to a substitution
    TG_BCAND = 2'd2,   // first slot of a run: B pulse or zero, decided at output
    TG_VIOL  = 2'd3    // last slot of a run: violation pulse
  } tag_e;

  typedef struct packed {
    logic raw;   // dual-rail bypass slot
    logic p;
    logic n;
    tag_e tag;
  } slot_t;

  localparam slot_t SLOT_IDLE = '{raw: 1'b1, p: 1'b0, n: 1'b0, tag: TG_DATA};

  function automatic logic zero_ok(slot_t x);
    return !x.raw && (x.tag == TG_DATA) && !x.p;
  endfunction
endpackage

// File: rtl/zs_enc_src.sv
module zs_enc_src
  import zs_enc_pkg::*;
(
  input  logic  ais_force,
  input  logic  rlb_en,
  input  logic  enc_bypass,
  input  logic  tx_d0,
  input  logic  tx_d1,
  input  logic  rlb_data,
  output slot_t src_slot
);
  always_comb begin
    src_slot     = '0;
    src_slot.tag = TG_DATA;
    if (ais_force) begin
      src_slot.p = 1'b1;
    end else if (rlb_en) begin
      src_slot.p = rlb_data;
    end else if (enc_bypass) begin
      src_slot.raw = 1'b1;
      src_slot.p   = tx_d0;
      src_slot.n   = tx_d1;
    end else begin
      src_slot.p = tx_d0;
    end
  end
endmodule

// File: rtl/zs_enc_window.sv
module zs_enc_window
  import zs_enc_pkg::*;
#(
  parameter int unsigned DEPTH   = WIN,
  parameter int unsigned LEN_E3  = RUN_E3,
  parameter int unsigned LEN_DS3 = RUN_DS3
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  mode_e3,
  input  slot_t in_slot,
  output slot_t out_slot
);
  slot_t s   [DEPTH];
  slot_t nxt [DEPTH];
  logic  hit_e3, hit_ds3, run_hit;
  int unsigned run_len;

  always_comb begin
    hit_e3  = zero_ok(in_slot);
    hit_ds3 = zero_ok(in_slot);
    for (int k = 0; k < int'(LEN_E3) - 1; k++)  hit_e3  = hit_e3  & zero_ok(s[k]);
    for (int k = 0; k < int'(LEN_DS3) - 1; k++) hit_ds3 = hit_ds3 & zero_ok(s[k]);
    run_hit = mode_e3 ? hit_e3 : hit_ds3;
    run_len = mode_e3 ? LEN_E3 : LEN_DS3;

    nxt[0] = in_slot;
    for (int k = 1; k < int'(DEPTH); k++) nxt[k] = s[k-1];

    if (run_hit) begin
      nxt[0].tag = TG_VIOL;
      for (int k = 1; k < int'(DEPTH); k++) begin
        if (k < int'(run_len) - 1)       nxt[k].tag = TG_SUBZ;
        else if (k == int'(run_len) - 1) nxt[k].tag = TG_BCAND;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < int'(DEPTH); k++) begin
      if (rst) s[k] <= SLOT_IDLE;
      else     s[k] <= nxt[k];
    end
  end

  assign out_slot = s[DEPTH-1];
endmodule

// File: rtl/zs_enc_polar.sv
module zs_enc_polar
  import zs_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  slot_t slot,
  output logic  line_pos,
  output logic  line_neg
);
  logic last_pos;   // polarity of the most recent pulse
  logic odd_cnt;    // odd number of pulses since the last violation

  always_ff @(posedge clk) begin
    if (rst) begin
      line_pos <= 1'b0;
      line_neg <= 1'b0;
      last_pos <= 1'b0;
      odd_cnt  <= 1'b0;
    end else begin
      line_pos <= 1'b0;
      line_neg <= 1'b0;
      if (slot.raw) begin
        line_pos <= slot.p;
        line_neg <= slot.n;
      end else begin
        unique case (slot.tag)
          TG_DATA, TG_BCAND: begin
            if ((slot.tag == TG_DATA && slot.p) || (slot.tag == TG_BCAND && !odd_cnt)) begin
              line_pos <= !last_pos;
              line_neg <= last_pos;
              last_pos <= !last_pos;
              odd_cnt  <= !odd_cnt;
            end
          end
          TG_VIOL: begin
            line_pos <= last_pos;
            line_neg <= !last_pos;
            odd_cnt  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/line_zs_encoder.sv
module line_zs_encoder
  import zs_enc_pkg::*;
#(
  parameter int unsigned DEPTH   = WIN,
  parameter int unsigned LEN_E3  = RUN_E3,
  parameter int unsigned LEN_DS3 = RUN_DS3
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_e3,
  input  logic enc_bypass,
  input  logic ais_force,
  input  logic rlb_en,
  input  logic tx_d0,
  input  logic tx_d1,
  input  logic rlb_data,
  output logic line_pos,
  output logic line_neg
);
  slot_t src_slot, win_out;

  zs_enc_src u_src (
    .ais_force (ais_force),
    .rlb_en    (rlb_en),
    .enc_bypass(enc_bypass),
    .tx_d0     (tx_d0),
    .tx_d1     (tx_d1),
    .rlb_data  (rlb_data),
    .src_slot  (src_slot)
  );

  zs_enc_window #(.DEPTH(DEPTH), .LEN_E3(LEN_E3), .LEN_DS3(LEN_DS3)) u_win (
    .clk     (clk),
    .rst     (rst),
    .mode_e3 (mode_e3),
    .in_slot (src_slot),
    .out_slot(win_out)
  );

  zs_enc_polar u_pol (
    .clk     (clk),
    .rst     (rst),
    .slot    (win_out),
    .line_pos(line_pos),
    .line_neg(line_neg)
  );
endmodule

// File: rtl/line_zs_encoder_chk.sv
module line_zs_encoder_chk (
  input logic clk,
  input logic rst,
  input logic mode_e3,
  input logic enc_bypass,
  input logic ais_force,
  input logic rlb_en,
  input logic line_pos,
  input logic line_neg
);
  logic [3:0] since_rst, stable_cnt, ais_cnt;
  logic [2:0] zrun;
  logic       prev_e3, prev_path;
  logic       coded_path;

  assign coded_path = !(enc_bypass && !ais_force && !rlb_en);

  always_ff @(posedge clk) begin
    prev_e3   <= mode_e3;
    prev_path <= coded_path;
    if (rst) begin
      since_rst  <= '0;
      stable_cnt <= '0;
      ais_cnt    <= '0;
      zrun       <= '0;
    end else begin
      if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
      if (!coded_path || mode_e3 != prev_e3 || coded_path != prev_path) stable_cnt <= '0;
      else if (stable_cnt != 4'hF) stable_cnt <= stable_cnt + 4'd1;
      if (!ais_force) ais_cnt <= '0;
      else if (ais_cnt != 4'hF) ais_cnt <= ais_cnt + 4'd1;
      if (stable_cnt < 4'd8 || line_pos || line_neg) zrun <= '0;
      else if (zrun != 3'd7) zrun <= zrun + 3'd1;
    end
  end

  // R5: both rails high only for a slot that came through the bypass path
  assert_rails_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 4'd6 && line_pos && line_neg) |-> $past(enc_bypass && !ais_force && !rlb_en, 5));

  // R9: held alarm gives a mark in every slot, alternating in polarity
  assert_ais_alt_R9: assert property (@(posedge clk) disable iff (rst)
    (ais_cnt >= 4'd8) |-> ((line_pos ^ line_neg) && (line_pos != $past(line_pos))));

  // R11: zero-run limit with HDB3
  assert_zero_run_e3_R11: assert property (@(posedge clk) disable iff (rst)
    (stable_cnt >= 4'd8 && mode_e3) |-> (zrun <= 3'd3));

  // R11: zero-run limit with B3ZS
  assert_zero_run_ds3_R11: assert property (@(posedge clk) disable iff (rst)
    (stable_cnt >= 4'd8 && !mode_e3) |-> (zrun <= 3'd2));
endmodule

bind line_zs_encoder line_zs_encoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_e3   (mode_e3),
  .enc_bypass(enc_bypass),
  .ais_force (ais_force),
  .rlb_en    (rlb_en),
  .line_pos  (line_pos),
  .line_neg  (line_neg)
);

// File: tb/test_line_zs_encoder.sv
`timescale 1ns/1ps
module test_line_zs_encoder;
  logic clk = 1'b0;
  logic rst, mode_e3, enc_bypass, ais_force, rlb_en, tx_d0, tx_d1, rlb_data;
  logic line_pos, line_neg;
  int   total = 0, bad = 0;

  logic m_bit [0:79];
  logic e_p   [0:79];
  logic e_n   [0:79];

  always #4 clk = ~clk;

  line_zs_encoder i_line_zs_encoder (
    .clk(clk), .rst(rst), .mode_e3(mode_e3), .enc_bypass(enc_bypass),
    .ais_force(ais_force), .rlb_en(rlb_en), .tx_d0(tx_d0), .tx_d1(tx_d1),
    .rlb_data(rlb_data), .line_pos(line_pos), .line_neg(line_neg)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual pos/neg=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Expected line for an NRZ stream m_bit[0:tot-1], from the requirements
  task automatic model(input int runlen, input int tot);
    logic last_pos = 1'b0;
    logic odd = 1'b0;
    int   skip = 0;
    for (int i = 0; i < tot; i++) begin
      logic all0;
      if (skip > 0) begin skip--; continue; end
      all0 = (i + runlen - 1 < tot);
      for (int k = 0; k < runlen; k++) if (i + k < tot && m_bit[i+k]) all0 = 1'b0;
      if (all0) begin
        for (int k = 0; k < runlen; k++) begin e_p[i+k] = 1'b0; e_n[i+k] = 1'b0; end
        if (!odd) begin
          e_p[i] = !last_pos; e_n[i] = last_pos; last_pos = !last_pos;
        end
        e_p[i+runlen-1] = last_pos; e_n[i+runlen-1] = !last_pos;
        odd  = 1'b0;
        skip = runlen - 1;
      end else if (m_bit[i]) begin
        e_p[i] = !last_pos; e_n[i] = last_pos; last_pos = !last_pos; odd = !odd;
      end else begin
        e_p[i] = 1'b0; e_n[i] = 1'b0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // One stream: drives va/vb/vl (LSB first), compares each output four edges later
  task automatic run_case(input string req, input logic e3, input logic byp, input logic ais,
                          input logic lb, input logic [63:0] va, input logic [63:0] vb,
                          input logic [63:0] vl, input int len);
    logic raw_path = byp && !ais && !lb;
    int   tot = len + 5;
    mode_e3 = e3; enc_bypass = byp; ais_force = ais; rlb_en = lb;
    tx_d0 = 1'b0; tx_d1 = 1'b0; rlb_data = 1'b0;
    do_reset();
    for (int j = 0; j < tot; j++) begin
      if (ais)            m_bit[j] = 1'b1;
      else if (j >= len)  m_bit[j] = 1'b1;
      else if (lb)        m_bit[j] = vl[j];
      else                m_bit[j] = va[j];
    end
    if (raw_path) begin
      for (int j = 0; j < len; j++) begin e_p[j] = va[j]; e_n[j] = vb[j]; end
    end else begin
      model(e3 ? 4 : 3, tot);
    end
    for (int j = 0; j < tot; j++) begin
      if (j >= 5) check(req, {line_pos, line_neg}, {e_p[j-5], e_n[j-5]});
      tx_d0    = (j < len) ? va[j] : !raw_path;
      tx_d1    = (j < len) ? vb[j] : 1'b0;
      rlb_data = (j < len) ? vl[j] : 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    mode_e3 = 1'b0; enc_bypass = 1'b0; ais_force = 1'b1; rlb_en = 1'b0;
    tx_d0 = 1'b1; tx_d1 = 1'b1; rlb_data = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", {line_pos, line_neg}, 2'b00);
    rst = 1'b0;
    repeat (8) @(negedge clk);                 // alarm traffic flowing
    rst = 1'b1;
    @(negedge clk);
    check("R1 after reset edge", {line_pos, line_neg}, 2'b00);
    rst = 1'b0;
    for (int j = 1; j <= 4; j++) begin
      @(negedge clk);
      check("R1 first four edges", {line_pos, line_neg}, 2'b00);
    end
    @(negedge clk);
    check("R2/R5 first mark positive at edge 5", {line_pos, line_neg}, 2'b10);
  endtask

  localparam logic [63:0] PAT_A = 64'h8001_00F0_1300_4C11;
  localparam logic [63:0] PAT_B = 64'h0000_0F00_0120_0001;
  localparam logic [63:0] PAT_C = 64'h0840_0004_2100_0009;

  initial begin
    rst = 1'b1; mode_e3 = 1'b0; enc_bypass = 1'b0; ais_force = 1'b0; rlb_en = 1'b0;
    tx_d0 = 1'b0; tx_d1 = 1'b0; rlb_data = 1'b0;
    t_reset();
    run_case("R2/R5/R6/R8 B3ZS pattern A",          1'b0, 1'b0, 1'b0, 1'b0, PAT_A, 64'h0, 64'h0, 64);
    run_case("R2/R6/R8 B3ZS pattern B",             1'b0, 1'b0, 1'b0, 1'b0, PAT_B, 64'h0, 64'h0, 64);
    run_case("R2/R7/R8 HDB3 pattern A",             1'b1, 1'b0, 1'b0, 1'b0, PAT_A, 64'h0, 64'h0, 64);
    run_case("R7/R8 HDB3 pattern B",                1'b1, 1'b0, 1'b0, 1'b0, PAT_B, 64'h0, 64'h0, 64);
    run_case("R7 HDB3 pattern C",                   1'b1, 1'b0, 1'b0, 1'b0, PAT_C, 64'h0, 64'h0, 64);
    run_case("R4 tx_d1 ignored in NRZ mode",        1'b1, 1'b0, 1'b0, 1'b0, PAT_C, ~PAT_C, 64'h0, 64);
    run_case("R3 bypass raw dual rail",             1'b0, 1'b1, 1'b0, 1'b0, PAT_A, PAT_B, 64'h0, 64);
    run_case("R9 alarm overrides data",             1'b0, 1'b0, 1'b1, 1'b0, PAT_B, 64'h0, 64'h0, 40);
    run_case("R9 alarm overrides bypass and loop",  1'b1, 1'b1, 1'b1, 1'b1, PAT_A, PAT_B, PAT_C, 40);
    run_case("R10 loopback data encoded",           1'b0, 1'b0, 1'b0, 1'b1, PAT_A, 64'h0, PAT_B, 64);
    run_case("R10 loopback overrides bypass",       1'b1, 1'b1, 1'b0, 1'b1, PAT_A, PAT_B, PAT_C, 64);
    run_case("R6/R11 B3ZS all zeros",               1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h0, 30);
    run_case("R7/R11 HDB3 all zeros",               1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 64'h0, 64'h0, 30);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule